// File: doc/BRIEF.md
# Register-Mapped GPIO Port Bank

This block holds a bank of bidirectional 8-bit general-purpose ports behind a simple synchronous CPU bus. Each port has a direction register and a data latch. A pin whose direction bit is 1 drives its latch value out. A pin whose direction bit is 0 is an input, and the CPU reads its level through a two-flop synchronizer. Writing the data register always updates the latch, whatever the direction.

Pull-up requests are stored one bit per 4-pin group. A pull-up reaches a pin only while that pin is an input. A control bit makes one designated port read back its latch instead of its pins. An unlock bit, the top bit of the last pull-up register, opens the upper port group. Until it is set, those ports drive nothing, apply no pull-ups, read as zero and ignore writes. One designated pin has no direction control and is always an input.

The bus reads combinationally: `bus_rdata` follows `bus_addr`. A write is strobed by `bus_we` and takes effect at the next rising clock edge. With the default 14 ports, the address map is as follows:
- Port p's direction register is at address 2p and its data register is at 2p+1.
- The pull-up registers are at 28 to 31. Register k, bit b, covers 4-pin group n = 8k+b: port n/2, low nibble when n is even, high nibble when n is odd.
- The control register is at 32. Bit 0 is the latch-read bit.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads 0 and `pin_out`, `pin_oe` and `pin_pu` are all 0.
- R2: A direction write (address 2p) takes effect at the next clock edge. Direction bit 1 means output, and the matching `pin_oe` bit follows it.
- R3: A data read (address 2p+1) returns, bit by bit, the latch for output pins and the synchronized pin level for input pins.
- R4: A data write updates the port latch whatever the direction, and `pin_out` shows the latch.
- R5: Pull-up bit n of the pull-up registers (register n/8, bit n%8) enables `pin_pu` on the 4 pins of its group, but only on pins whose direction bit is 0.
- R6: When control bit 0 (address 32) is 1, a read of port 1 data returns its latch on all 8 pins, regardless of direction.
- R7: While the unlock bit (address 31, bit 7) is 0, ports 11 to 13 have `pin_oe`, `pin_pu` and `pin_out` at 0, read as 0, and ignore writes.
- R8: Once the unlock bit is 1, ports 11 to 13 behave like the other ports.
- R9: Port 8 pin 5 has no direction bit. That bit reads 0 and ignores writes, and `pin_oe` for that pin stays 0.
- R10: A pin level change becomes visible to a data read after two clock edges, and not after one.
- R11: Addresses 33 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 112 | Pin levels, port p at bits 8p+7..8p |
| pin_out | output | 112 | Output value for each pin |
| pin_oe | output | 112 | Output enable for each pin |
| pin_pu | output | 112 | Pull-up enable for each pin |

## Verification
The block has three latencies:
- Register writes, and the pad controls that follow from them, change at the first rising edge after the strobe.
- Read data is combinational on the address.
- Pin levels reach the read path after two rising edges.

The bench drives inputs on the falling edge. It finishes a write by dropping the strobe one falling edge later, then checks on the following falling edges. Random pin values are applied at least two edges before any read that depends on them. A directed case samples a pin change after one edge, to see the old value, and again after two edges, to see the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PW = 8;

  // Read value of one port: latch for outputs, synced pin for inputs,
  // or the latch on every pin when forced.
  function automatic logic [PW-1:0] rd_mix(input logic [PW-1:0] dir,
                                           input logic [PW-1:0] lat,
                                           input logic [PW-1:0] pin,
                                           input logic          force_lat);
    if (force_lat) return lat;
    return (dir & lat) | (~dir & pin);
  endfunction

  // Expand two nibble pull-up bits onto 8 pins, gated by input direction.
  function automatic logic [PW-1:0] pu_expand(input logic [1:0]    nib,
                                              input logic [PW-1:0] dir,
                                              input logic          usable);
    logic [PW-1:0] grp;
    grp = {{(PW/2){nib[1]}}, {(PW/2){nib[0]}}};
    return grp & ~dir & {PW{usable}};
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter logic [PW-1:0] NODIR_MASK  = '0,
  parameter bit            LATCH_RD_EN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_we,
  input  logic          dat_we,
  input  logic [PW-1:0] wdata,
  input  logic          force_lat,
  input  logic [1:0]    pu_nib,
  input  logic          usable,
  input  logic [PW-1:0] pin_s,
  output logic [PW-1:0] dir_rd,
  output logic [PW-1:0] dat_rd,
  output logic [PW-1:0] out_q,
  output logic [PW-1:0] oe,
  output logic [PW-1:0] pu
);
  logic [PW-1:0] dir_q;
  logic [PW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (dir_we && usable) dir_q <= wdata & ~NODIR_MASK;
      if (dat_we && usable) lat_q <= wdata;
    end
  end

  always_comb begin
    dir_rd = dir_q & {PW{usable}};
    dat_rd = usable ? rd_mix(dir_q, lat_q, pin_s, force_lat && LATCH_RD_EN) : '0;
    out_q  = lat_q & {PW{usable}};
    oe     = dir_q & {PW{usable}};
    pu     = pu_expand(pu_nib, dir_q, usable);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NPORTS     = 14,
  parameter int AW         = 6,
  parameter int LOCK_BASE  = 11,
  parameter int LATCH_PORT = 1,
  parameter int NODIR_PORT = 8,
  parameter int NODIR_BIT  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_we,
  output logic [7:0]           bus_rdata,
  input  logic [NPORTS*8-1:0]  pin_in,
  output logic [NPORTS*8-1:0]  pin_out,
  output logic [NPORTS*8-1:0]  pin_oe,
  output logic [NPORTS*8-1:0]  pin_pu
);
  localparam int NPU       = (2*NPORTS + 8) / 8;
  localparam int PU_BASE   = 2*NPORTS;
  localparam int CTRL_ADDR = PU_BASE + NPU;
  localparam int NREG      = CTRL_ADDR + 1;

  logic [NPU*8-1:0]    pu_q;
  logic                latch_rd_q;
  logic                unlocked;
  logic [NPORTS*8-1:0] pin_s;
  logic [PW-1:0]       dir_rd [NPORTS];
  logic [PW-1:0]       dat_rd [NPORTS];

  assign unlocked = pu_q[NPU*8-1];

  gpio_sync #(.W(NPORTS*8)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  for (genvar k = 0; k < NPU; k++) begin : g_pu
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pu_q[k*8 +: 8] <= '0;
      else if (bus_we && bus_addr == AW'(PU_BASE + k)) pu_q[k*8 +: 8] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_rd_q <= 1'b0;
    else if (bus_we && bus_addr == AW'(CTRL_ADDR)) latch_rd_q <= bus_wdata[0];
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [PW-1:0] NDM = (p == NODIR_PORT) ? PW'(1 << NODIR_BIT) : '0;
    logic usable;
    assign usable = (p < LOCK_BASE) || unlocked;
    gpio_port #(.NODIR_MASK(NDM), .LATCH_RD_EN(p == LATCH_PORT)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_we   (bus_we && bus_addr == AW'(2*p)),
      .dat_we   (bus_we && bus_addr == AW'(2*p + 1)),
      .wdata    (bus_wdata),
      .force_lat(latch_rd_q),
      .pu_nib   (pu_q[2*p +: 2]),
      .usable   (usable),
      .pin_s    (pin_s[p*8 +: 8]),
      .dir_rd   (dir_rd[p]),
      .dat_rd   (dat_rd[p]),
      .out_q    (pin_out[p*8 +: 8]),
      .oe       (pin_oe[p*8 +: 8]),
      .pu       (pin_pu[p*8 +: 8])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (int'(bus_addr) == 2*p)     bus_rdata = dir_rd[p];
      if (int'(bus_addr) == 2*p + 1) bus_rdata = dat_rd[p];
    end
    for (int k = 0; k < NPU; k++)
      if (int'(bus_addr) == PU_BASE + k) bus_rdata = pu_q[k*8 +: 8];
    if (int'(bus_addr) == CTRL_ADDR) bus_rdata = {7'b0, latch_rd_q};
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPORTS     = 14,
  parameter int AW         = 6,
  parameter int LOCK_BASE  = 11,
  parameter int NODIR_PORT = 8,
  parameter int NODIR_BIT  = 5,
  parameter int NREG       = 33
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic [7:0]          bus_rdata,
  input logic [NPORTS*8-1:0] pin_out,
  input logic [NPORTS*8-1:0] pin_oe,
  input logic [NPORTS*8-1:0] pin_pu,
  input logic                unlocked
);
  localparam logic [NPORTS*8-1:0] UPPER = {(NPORTS*8){1'b1}} << (LOCK_BASE*8);

  // R5: pull-up never on a driven pin
  a_r5_pu_only_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  // R7: locked upper group stays quiet
  a_r7_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> ((pin_oe & UPPER) == '0 && (pin_pu & UPPER) == '0 && (pin_out & UPPER) == '0));

  // R2: pad controls only move after a write strobe
  a_r2_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> ($stable(pin_oe) && $stable(pin_out)));

  // R11: unmapped addresses read zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) >= NREG) |-> (bus_rdata == 8'h00));

  if (NODIR_PORT < NPORTS) begin : g_nodir
    // R9: the pin without a direction bit never drives
    a_r9_nodir_input: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[NODIR_PORT*8 + NODIR_BIT]);
  end
endmodule

bind gpio_bank gpio_bank_chk #(
  .NPORTS(NPORTS), .AW(AW), .LOCK_BASE(LOCK_BASE),
  .NODIR_PORT(NODIR_PORT), .NODIR_BIT(NODIR_BIT), .NREG(NREG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_pu(pin_pu), .unlocked(unlocked)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  localparam int N     = 14;
  localparam int AW    = 6;
  localparam int NPU   = 4;
  localparam int PUB   = 28;
  localparam int CTRL  = 32;
  localparam int NREG  = 33;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic            bus_we = 1'b0;
  logic [7:0]      bus_rdata;
  logic [N*8-1:0]  pin_in = '0;
  logic [N*8-1:0]  pin_out, pin_oe, pin_pu;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_dir [N];
  logic [7:0] m_lat [N];
  logic [7:0] m_pu  [NPU];
  logic       m_ctrl;

  always #4 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  function automatic bit m_open(int p);
    return (p < 11) || m_pu[NPU-1][7];
  endfunction

  function automatic void m_write(int a, logic [7:0] d);
    int p;
    if (a < 2*N) begin
      p = a / 2;
      if (!m_open(p)) return;
      if (a % 2 == 0) begin
        m_dir[p] = d;
        if (p == 8) m_dir[p][5] = 1'b0;
      end else m_lat[p] = d;
    end else if (a < CTRL) m_pu[a-PUB] = d;
    else if (a == CTRL) m_ctrl = d[0];
  endfunction

  function automatic logic [7:0] m_read(int a);
    int p;
    logic [7:0] r;
    if (a >= NREG) return 8'h00;
    if (a == CTRL) return {7'b0, m_ctrl};
    if (a >= PUB) return m_pu[a-PUB];
    p = a / 2;
    if (!m_open(p)) return 8'h00;
    if (a % 2 == 0) return m_dir[p];
    for (int b = 0; b < 8; b++)
      r[b] = (m_dir[p][b] || (p == 1 && m_ctrl)) ? m_lat[p][b] : pin_in[p*8+b];
    return r;
  endfunction

  function automatic logic pu_bit(int p, int b);
    int n;
    n = 2*p + b/4;
    return m_open(p) && !m_dir[p][b] && m_pu[n/8][n%8];
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, int a);
    @(negedge clk);
    bus_addr = AW'(a);
    #1;
    check8(tag, bus_rdata, m_read(a));
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    m_write(a, d);
  endtask

  task automatic pads_chk(string tag);
    logic [N*8-1:0] eo, eoe, epu;
    for (int p = 0; p < N; p++)
      for (int b = 0; b < 8; b++) begin
        eo[p*8+b]  = m_open(p) && m_lat[p][b];
        eoe[p*8+b] = m_open(p) && m_dir[p][b];
        epu[p*8+b] = pu_bit(p, b);
      end
    checks++;
    if (pin_out !== eo || pin_oe !== eoe || pin_pu !== epu) begin
      fails++;
      $display("FAIL %s pads actual out=%h oe=%h pu=%h expected out=%h oe=%h pu=%h",
               tag, pin_out, pin_oe, pin_pu, eo, eoe, epu);
    end
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin m_dir[p] = 0; m_lat[p] = 0; end
    for (int k = 0; k < NPU; k++) m_pu[k] = 0;
    m_ctrl = 0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < NREG; a++) rd_chk("R1 reset read", a);
    pads_chk("R1 reset pads");

    // R2 / R4: direction and latch on port 0
    wr(0, 8'hF0);
    pads_chk("R2 direction sets oe");
    wr(1, 8'h3C);
    pads_chk("R4 latch drives out");
    pin_in[7:0] = 8'hA5;
    repeat (2) @(negedge clk);
    rd_chk("R3 mixed read", 1);

    // R10: synchronizer latency
    pin_in[7:0] = 8'h5A;
    @(negedge clk);
    bus_addr = AW'(1); #1;
    check8("R10 one edge old", bus_rdata, 8'h35);
    @(negedge clk); #1;
    check8("R10 two edges new", bus_rdata, 8'h3A);

    // R5: pull-up nibbles gated by direction
    wr(PUB, 8'h03);
    pads_chk("R5 pullup gating");

    // R6: latch read-back on port 1
    wr(2, 8'h0F); wr(3, 8'h5A);
    pin_in[15:8] = 8'hC3;
    repeat (2) @(negedge clk);
    rd_chk("R6 normal read", 3);
    wr(CTRL, 8'h01);
    rd_chk("R6 forced latch", 3);
    check8("R6 latch value", bus_rdata, 8'h5A);

    // R9: no-direction pin
    wr(16, 8'hFF);
    rd_chk("R9 dir readback", 16);
    check8("R9 bit5 clear", bus_rdata, 8'hDF);
    pads_chk("R9 oe pads");

    // R7: locked upper ports
    wr(24, 8'hFF); wr(25, 8'hAA); wr(PUB+3, 8'h0F);
    rd_chk("R7 locked dir", 24);
    rd_chk("R7 locked dat", 25);
    pads_chk("R7 locked pads");

    // R8: unlock
    wr(PUB+3, 8'h8F);
    wr(24, 8'h0F); wr(25, 8'hAA);
    rd_chk("R8 unlocked dir", 24);
    check8("R8 dir value", bus_rdata, 8'h0F);
    pads_chk("R8 unlocked pads");

    // R11: unmapped addresses
    wr(40, 8'hFF); wr(63, 8'h77);
    rd_chk("R11 unmapped 40", 40);
    rd_chk("R11 unmapped 33", 33);
    for (int a = 0; a < NREG; a++) rd_chk("R11 no side effect", a);

    // Random phase
    for (int it = 0; it < 150; it++) begin
      int a;
      a = int'($urandom % 37);
      if (it % 5 == 0) a = PUB + 3;
      @(negedge clk);
      pin_in = {$urandom, $urandom, $urandom, $urandom};
      wr(a, 8'($urandom));
      @(negedge clk);
      for (int r = 0; r < 37; r++) rd_chk("R3 random read", r);
      pads_chk("R5 random pads");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule